// File: doc/BRIEF.md
# Rotating Register File with Base Offset

This block is a small register file for a statically scheduled loop engine. Its logical register space has two regions. A short fixed region is addressed directly. A larger rotating region is addressed through a base value. For a specifier in the rotating region, the block adds the base to the register's offset within that region, modulo the region size, to form the physical index. Every loop-closing branch lowers the base by one. A value written to register Rn in one iteration therefore shows up as R(n+1) in the next. The compiler uses this to encode a producer-to-consumer latency as a gap in register numbers, which avoids copying values between iterations.

The file has two combinational read ports and one write port. Software can load the base directly. Anything written in a cycle is visible on a read of the same register in that cycle. The loop counting, the predicates and the instruction decode sit outside this block.

Top module: `rot_regfile`

## Requirements
- R1: After reset the base reads 0 and every logical register reads 0.
- R2: Specifiers 0 to 7 address the fixed region directly. Their contents do not depend on the base.
- R3: A specifier s from 8 to 23 reaches rotating entry (s - 8 + base) mod 16.
- R4: A cycle with `loopBranch` high and `baseWrEn` low lowers the base by one, wrapping from 0 to 15. With both low, the base holds.
- R5: A value written to Rn (n from 8 to 22) reads back as R(n+1) once exactly one loop branch has taken effect.
- R6: `baseWrEn` loads `baseWrVal` into the base on the next edge. It takes priority over a loop branch in the same cycle.
- R7: A write that shares its cycle with a loop branch or a base load is placed using the base value from before the update.
- R8: A read of the register being written in the same cycle returns the new write data (write-first).
- R9: Specifiers 24 to 31 read as 0, and writes to them change no register.
- R10: The two read ports decode and return data independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddrA | input | 5 | Read port A logical specifier |
| rdAddrB | input | 5 | Read port B logical specifier |
| rdDataA | output | 32 | Read port A data, combinational |
| rdDataB | output | 32 | Read port B data, combinational |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write logical specifier |
| wrData | input | 32 | Write data |
| loopBranch | input | 1 | Loop-closing branch executed; lowers the base |
| baseWrEn | input | 1 | Software load of the base |
| baseWrVal | input | 4 | New base value |
| baseOut | output | 4 | Current base |

## Verification
The bench drives the base through its wrap from 0 to 15. A design that decrements without the modulo would either lose the wrap or alias the wrong entries. The bench also fires a loop branch, a base load and a write in one cycle. A design that used the updated base for the write address would then put the data one entry off, and the following R(n+1) read would return stale data. Same-cycle read-after-write on both ports exposes a read-first design, because the value returned would be one cycle old. Writes to the unmapped specifiers, followed by a sweep of every register, catch a decoder that folds those specifiers into the rotating region.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  parameter int unsigned RRF_DATA_W   = 32;
  parameter int unsigned RRF_FIX_REGS = 8;
  parameter int unsigned RRF_ROT_REGS = 16;
  parameter int unsigned RRF_SPEC_W   = 5;
  parameter int unsigned RRF_RD_PORTS = 2;

  localparam int unsigned RRF_MAPPED    = RRF_FIX_REGS + RRF_ROT_REGS;
  localparam int unsigned RRF_BASE_W    = $clog2(RRF_ROT_REGS);
  localparam int unsigned RRF_FIX_IDX_W = $clog2(RRF_FIX_REGS);
  localparam int unsigned RRF_ROT_IDX_W = $clog2(RRF_ROT_REGS);
  localparam int unsigned RRF_IDX_W     = (RRF_FIX_IDX_W > RRF_ROT_IDX_W) ? RRF_FIX_IDX_W : RRF_ROT_IDX_W;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FIX  = 2'd1,
    SEL_ROT  = 2'd2
  } regSel_e;

  typedef struct packed {
    regSel_e              sel;
    logic [RRF_IDX_W-1:0] idx;
  } regLoc_t;

  typedef struct packed {
    logic                           wrStrobe;
    regLoc_t                        wrLoc;
    regLoc_t [RRF_RD_PORTS-1:0]     rdLoc;
  } rrfCtrl_t;
endpackage

// File: rtl/rrf_ctrl.sv
module rrf_ctrl
  import rrf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [RRF_SPEC_W-1:0] rdAddr [RRF_RD_PORTS],
  input  logic                  wrEn,
  input  logic [RRF_SPEC_W-1:0] wrAddr,
  input  logic                  loopBranch,
  input  logic                  baseWrEn,
  input  logic [RRF_BASE_W-1:0] baseWrVal,
  output rrfCtrl_t              ctrl,
  output logic [RRF_BASE_W-1:0] base
);
  localparam logic [RRF_BASE_W-1:0] BASE_TOP = RRF_BASE_W'(RRF_ROT_REGS - 1);

  // Map one logical specifier to a region and a physical index.
  function automatic regLoc_t locate(input logic [RRF_SPEC_W-1:0] spec,
                                     input logic [RRF_BASE_W-1:0] curBase);
    regLoc_t loc;
    int unsigned specInt;
    int unsigned rotOff;
    specInt = 32'(spec);
    loc.sel = SEL_NONE;
    loc.idx = '0;
    if (specInt < RRF_FIX_REGS) begin
      loc.sel = SEL_FIX;
      loc.idx = RRF_IDX_W'(specInt);
    end else if (specInt < RRF_MAPPED) begin
      rotOff  = (specInt - RRF_FIX_REGS + 32'(curBase)) % RRF_ROT_REGS;
      loc.sel = SEL_ROT;
      loc.idx = RRF_IDX_W'(rotOff);
    end
    return loc;
  endfunction

  // Base register: software load wins over a loop branch.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      base <= '0;
    end else if (baseWrEn) begin
      base <= baseWrVal;
    end else if (loopBranch) begin
      base <= (base == '0) ? BASE_TOP : base - 1'b1;
    end
  end

  regLoc_t rdLoc [RRF_RD_PORTS];
  regLoc_t wrLoc;

  for (genvar p = 0; p < RRF_RD_PORTS; p++) begin : g_rdMap
    assign rdLoc[p] = locate(rdAddr[p], base);
  end

  // Write uses the base before this cycle's update.
  assign wrLoc = locate(wrAddr, base);

  always_comb begin
    ctrl.wrStrobe = wrEn && (wrLoc.sel != SEL_NONE);
    ctrl.wrLoc    = wrLoc;
    for (int p = 0; p < RRF_RD_PORTS; p++) begin
      ctrl.rdLoc[p] = rdLoc[p];
    end
  end
endmodule

// File: rtl/rrf_datapath.sv
module rrf_datapath
  import rrf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  rrfCtrl_t              ctrl,
  input  logic [RRF_DATA_W-1:0] wrData,
  output logic [RRF_DATA_W-1:0] rdData [RRF_RD_PORTS]
);
  logic [RRF_DATA_W-1:0] fixRegs [RRF_FIX_REGS];
  logic [RRF_DATA_W-1:0] rotRegs [RRF_ROT_REGS];

  logic wrFix;
  logic wrRot;
  assign wrFix = ctrl.wrStrobe && (ctrl.wrLoc.sel == SEL_FIX);
  assign wrRot = ctrl.wrStrobe && (ctrl.wrLoc.sel == SEL_ROT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RRF_FIX_REGS; i++) fixRegs[i] <= '0;
    end else if (wrFix) begin
      fixRegs[ctrl.wrLoc.idx[RRF_FIX_IDX_W-1:0]] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RRF_ROT_REGS; i++) rotRegs[i] <= '0;
    end else if (wrRot) begin
      rotRegs[ctrl.wrLoc.idx[RRF_ROT_IDX_W-1:0]] <= wrData;
    end
  end

  for (genvar p = 0; p < RRF_RD_PORTS; p++) begin : g_rdPort
    logic [RRF_DATA_W-1:0] arrayData;
    logic                  hitWrite;

    always_comb begin
      arrayData = '0;
      case (ctrl.rdLoc[p].sel)
        SEL_FIX: arrayData = fixRegs[ctrl.rdLoc[p].idx[RRF_FIX_IDX_W-1:0]];
        SEL_ROT: arrayData = rotRegs[ctrl.rdLoc[p].idx[RRF_ROT_IDX_W-1:0]];
        default: arrayData = '0;
      endcase
    end

    assign hitWrite  = ctrl.wrStrobe && (ctrl.rdLoc[p].sel != SEL_NONE) &&
                       (ctrl.wrLoc == ctrl.rdLoc[p]);
    assign rdData[p] = hitWrite ? wrData : arrayData;
  end
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
  import rrf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [RRF_SPEC_W-1:0] rdAddrA,
  input  logic [RRF_SPEC_W-1:0] rdAddrB,
  output logic [RRF_DATA_W-1:0] rdDataA,
  output logic [RRF_DATA_W-1:0] rdDataB,
  input  logic                  wrEn,
  input  logic [RRF_SPEC_W-1:0] wrAddr,
  input  logic [RRF_DATA_W-1:0] wrData,
  input  logic                  loopBranch,
  input  logic                  baseWrEn,
  input  logic [RRF_BASE_W-1:0] baseWrVal,
  output logic [RRF_BASE_W-1:0] baseOut
);
  rrfCtrl_t              ctrl;
  logic [RRF_SPEC_W-1:0] rdAddr [RRF_RD_PORTS];
  logic [RRF_DATA_W-1:0] rdData [RRF_RD_PORTS];

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  rrf_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdAddr    (rdAddr),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .loopBranch(loopBranch),
    .baseWrEn  (baseWrEn),
    .baseWrVal (baseWrVal),
    .ctrl      (ctrl),
    .base      (baseOut)
  );

  rrf_datapath i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .wrData(wrData),
    .rdData(rdData)
  );
endmodule

// File: rtl/rrf_checker.sv
module rrf_checker
  import rrf_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [RRF_SPEC_W-1:0] rdAddrA,
  input logic [RRF_SPEC_W-1:0] rdAddrB,
  input logic [RRF_DATA_W-1:0] rdDataA,
  input logic [RRF_DATA_W-1:0] rdDataB,
  input logic                  wrEn,
  input logic [RRF_SPEC_W-1:0] wrAddr,
  input logic [RRF_DATA_W-1:0] wrData,
  input logic                  loopBranch,
  input logic                  baseWrEn,
  input logic [RRF_BASE_W-1:0] baseWrVal,
  input logic [RRF_BASE_W-1:0] baseOut
);
  localparam logic [RRF_BASE_W-1:0] BASE_TOP = RRF_BASE_W'(RRF_ROT_REGS - 1);

  logic wrMapped;
  assign wrMapped = 32'(wrAddr) < RRF_MAPPED;

  p_base_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |=> baseOut == $past(baseWrVal));

  p_base_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (loopBranch && !baseWrEn) |=>
      baseOut == (($past(baseOut) == '0) ? BASE_TOP : $past(baseOut) - 1'b1));

  p_base_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!loopBranch && !baseWrEn) |=> $stable(baseOut));

  p_bypass_a_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrMapped && wrAddr == rdAddrA) |-> rdDataA == wrData);

  p_bypass_b_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrMapped && wrAddr == rdAddrB) |-> rdDataB == wrData);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (32'(rdAddrA) >= RRF_MAPPED) |-> rdDataA == '0);

  p_fix_base_free_r2: assert property (@(posedge clk) disable iff (!rstN)
    (32'(rdAddrA) < RRF_FIX_REGS && rdAddrA == $past(rdAddrA) &&
     !$past(wrEn) && !wrEn) |-> rdDataA == $past(rdDataA));
endmodule

bind rot_regfile rrf_checker i_rrfChecker (.*);

// File: tb/test_rot_regfile.sv
module test_rot_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, loopBranch = 1'b0, baseWrEn = 1'b0;
  logic [3:0]  baseWrVal = '0;
  logic [3:0]  baseOut;

  int nChecks = 0;
  int nFail   = 0;
  string curReq = "R1";

  logic [31:0] mFix [8];
  logic [31:0] mRot [16];
  int          mBase = 0;

  always #5 clk = ~clk;

  rot_regfile i_rot_regfile (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .loopBranch(loopBranch), .baseWrEn(baseWrEn),
    .baseWrVal(baseWrVal), .baseOut(baseOut)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input int spec);
    if (wrEn && int'(wrAddr) == spec && spec < 24) return wrData;
    if (spec < 8) return mFix[spec];
    if (spec < 24) return mRot[(spec - 8 + mBase) % 16];
    return 32'h0;
  endfunction

  // One cycle: drive at negedge, compare before the edge, update model after it.
  task automatic step(input int rA, input int rB, input logic we, input int wa,
                      input logic [31:0] wd, input logic lb, input logic bw, input int bv);
    @(negedge clk);
    rdAddrA = 5'(rA); rdAddrB = 5'(rB);
    wrEn = we; wrAddr = 5'(wa); wrData = wd;
    loopBranch = lb; baseWrEn = bw; baseWrVal = 4'(bv);
    #1;
    chk(rdDataA == mRead(rA), curReq, "port A", rdDataA, mRead(rA));
    chk(rdDataB == mRead(rB), curReq, "port B", rdDataB, mRead(rB));
    chk(baseOut == 4'(mBase), curReq, "base", 32'(baseOut), 32'(mBase));
    @(posedge clk);
    if (we && wa < 8) mFix[wa] = wd;
    else if (we && wa < 24) mRot[(wa - 8 + mBase) % 16] = wd;
    if (bw) mBase = bv;
    else if (lb) mBase = (mBase + 15) % 16;
  endtask

  task automatic rd(input int rA, input int rB);
    step(rA, rB, 1'b0, 0, 32'h0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mFix[i] = '0;
    for (int i = 0; i < 16; i++) mRot[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    curReq = "R1";
    for (int s = 0; s < 32; s += 2) rd(s, s + 1);

    // R2: fixed region ignores the base
    curReq = "R2";
    for (int s = 0; s < 8; s++) step(s, 0, 1'b1, s, 32'hF000_0000 + 32'(s), 1'b0, 1'b0, 0);
    for (int k = 0; k < 5; k++) step(k, 7 - k, 1'b0, 0, 32'h0, 1'b1, 1'b0, 0);
    for (int s = 0; s < 8; s++) rd(s, s);

    // R3: rotating mapping with a loaded base
    curReq = "R3";
    step(0, 0, 1'b0, 0, 32'h0, 1'b0, 1'b1, 5);
    for (int s = 8; s < 24; s++) step(8, s, 1'b1, s, 32'hA000_0000 + 32'(s), 1'b0, 1'b0, 0);
    step(0, 0, 1'b0, 0, 32'h0, 1'b0, 1'b1, 0);
    for (int s = 8; s < 24; s += 2) rd(s, s + 1);

    // R4: decrement and wrap 0 -> 15
    curReq = "R4";
    for (int k = 0; k < 20; k++) step(8 + k % 16, 23 - k % 16, 1'b0, 0, 32'h0, 1'b1, 1'b0, 0);
    rd(8, 9);

    // R5: Rn written this iteration reads as R(n+1) next iteration
    curReq = "R5";
    for (int i = 0; i < 20; i++) begin
      step(12, 9, 1'b1, 8, 32'h5500 + 32'(i), 1'b1, 1'b0, 0);
      if (i > 0) chk(rdDataB == 32'h5500 + 32'(i - 1), "R5", "R9 after branch",
                     rdDataB, 32'h5500 + 32'(i - 1));
    end

    // R6: base load beats a same-cycle branch
    curReq = "R6";
    step(0, 0, 1'b0, 0, 32'h0, 1'b1, 1'b1, 11);
    rd(0, 0);
    chk(baseOut == 4'd11, "R6", "base after load+branch", 32'(baseOut), 32'd11);

    // R7: write uses the pre-update base
    curReq = "R7";
    step(0, 0, 1'b1, 15, 32'h7777_0001, 1'b1, 1'b0, 0);
    rd(16, 15);
    chk(rdDataA == 32'h7777_0001, "R7", "R16 after branch", rdDataA, 32'h7777_0001);
    step(0, 0, 1'b1, 20, 32'h7777_0002, 1'b0, 1'b1, 3);
    rd(20, 20);
    step(0, 0, 1'b0, 0, 32'h0, 1'b0, 1'b1, 0);
    rd(20, 8);

    // R8: write-first on both ports
    curReq = "R8";
    step(10, 10, 1'b1, 10, 32'h8888_0010, 1'b0, 1'b0, 0);
    step(3, 3, 1'b1, 3, 32'h8888_0003, 1'b1, 1'b0, 0);
    chk(rdDataA == 32'h8888_0003, "R8", "bypass fixed", rdDataA, 32'h8888_0003);

    // R9: unmapped specifiers
    curReq = "R9";
    for (int s = 24; s < 32; s++) step(s, s, 1'b1, s, 32'hDEAD_0000 + 32'(s), 1'b0, 1'b0, 0);
    for (int s = 0; s < 32; s += 2) rd(s, s + 1);

    // R10: independent ports under mixed traffic
    curReq = "R10";
    for (int i = 0; i < 400; i++) begin
      step(int'($urandom_range(31)), int'($urandom_range(31)),
           1'($urandom_range(1)), int'($urandom_range(27)), $urandom(),
           1'($urandom_range(2) == 0), 1'($urandom_range(9) == 0),
           int'($urandom_range(15)));
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule